// File: doc/BRIEF.md
# Audio link reset sequencer

This block drives the two reset mechanisms of a serial audio codec link from a small control register. One register bit is an active-low cold-reset control that feeds the codec reset pin without any intermediate logic. That bit comes out of reset at zero, so the link stays in cold reset until software releases it. Software must hold cold reset for at least the codec's minimum time before releasing it. The bit keeps its value for as long as the block is powered, so a link that was released before a suspend is not reset again on resume.

The second bit requests a warm reset. A warm reset raises the sync output for a fixed number of system clocks, which wakes a suspended codec while its internal registers are kept. The bit clears itself once the pulse is over and the codec's bit clock is seen running again.

The block samples the bit clock that the codec supplies and treats it as running while an edge has appeared within a fixed window of system clocks. A warm request made while the bit clock runs is ignored. A warm request made while cold reset is held is also ignored.

Top module: `link_rst_seq`

## Requirements
- R1: After reset, codec_rst_n is 0, sync_out is 0 and rd_data is 2'b00.
- R2: A write (wr_en high) loads wr_data[0] into the cold-release bit. From the next cycle that value appears on codec_rst_n and on rd_data[0], where 0 means cold reset is held.
- R3: A write with wr_data[1]=1 is accepted when cold reset is released, the bit clock is stopped and no warm reset is in progress. When it is accepted, sync_out is high for exactly SYNC_CYC consecutive cycles, starting the cycle after the write.
- R4: From an accepted warm write until its completion, rd_data[1] reads 1. This includes any time after the pulse during which the bit clock is still stopped. rd_data[1] returns to 0 only after the bit clock is detected running.
- R5: A warm write made while the bit clock is detected running is ignored: sync_out stays 0 and rd_data[1] stays 0.
- R6: A warm write is ignored while cold reset is held. This applies even when the same write releases cold reset: codec_rst_n goes to 1, while sync_out and rd_data[1] stay 0.
- R7: The bit clock counts as stopped once WIN_CYC system clocks pass without an edge. After that, a warm write is accepted again.
- R8: Writing 0 to wr_data[1] never clears a warm reset in progress. A write with wr_data[0]=0 aborts one: on the next cycle sync_out, rd_data[1] and codec_rst_n are all 0.
- R9: sync_out is never high while codec_rst_n is 0.
- R10: With wr_en low, wr_data has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 2 | Write data: bit 0 cold release, bit 1 warm request |
| rd_data | output | 2 | Read data: bit 0 cold release, bit 1 warm in progress |
| bclk_in | input | 1 | Codec bit clock, asynchronous to clk |
| codec_rst_n | output | 1 | Active-low cold reset to the codec |
| sync_out | output | 1 | Sync line, high during the warm pulse |

## Verification
Two functions can meet in a single write: releasing cold reset and requesting a warm reset. The bench provokes this with wr_data=2'b11 while cold reset is held, then checks that codec_rst_n rises and that neither sync_out nor rd_data[1] moves.

A warm-reset abort and the warm state also meet in one cycle. The bench writes cold-hold in the middle of a pulse and expects sync_out, rd_data[1] and codec_rst_n all low on the next cycle. A bound checker requires that sync_out never appears without codec_rst_n.

// File: rtl/lrs_pkg.sv
// Package: shared field positions and warm-reset state encoding.
// Assumes a two-bit control register: bit 0 cold release, bit 1 warm.
package lrs_pkg;
    localparam int COLD_BIT = 0;
    localparam int WARM_BIT = 1;
    localparam int REG_W    = 2;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_PULSE = 2'd1,
        WS_WAIT  = 2'd2
    } warm_st_t;
endpackage

// File: rtl/lrs_bclk_mon.sv
// Module: lrs_bclk_mon
// Synchronises the codec bit clock and reports it active while an edge
// has been seen within WIN_CYC system clocks.
// Assumes bclk_in is asynchronous and slower than clk/2.
module lrs_bclk_mon #(
    parameter int WIN_CYC = 16,
    parameter int STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    output logic bclk_act
);
    localparam int CW = $clog2(WIN_CYC + 1);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic [CW-1:0]     idle_cnt;
    logic              edge_seen;

    // Synchroniser chain for the asynchronous bit clock.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= bclk_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Hold the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign edge_seen = sync_q[STAGES-1] ^ prev_q;

    // Window counter: restart on an edge, drop activity when it expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            bclk_act <= 1'b0;
        end else if (edge_seen) begin
            idle_cnt <= '0;
            bclk_act <= 1'b1;
        end else if (idle_cnt == CW'(WIN_CYC - 1)) begin
            bclk_act <= 1'b0;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lrs_warm_fsm.sv
// Module: lrs_warm_fsm
// Drives the sync pulse of a warm reset and waits for the bit clock to
// return before declaring the warm reset complete.
// Assumes start is only raised while idle; abort takes priority.
module lrs_warm_fsm
    import lrs_pkg::*;
#(
    parameter int SYNC_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    input  logic bclk_act,
    output logic sync_out,
    output logic busy
);
    localparam int PW = $clog2(SYNC_CYC + 1);

    warm_st_t      st_q;
    logic [PW-1:0] pcnt;

    // State register with pulse-length counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= WS_IDLE;
            pcnt <= '0;
        end else if (abort) begin
            st_q <= WS_IDLE;
            pcnt <= '0;
        end else begin
            case (st_q)
                WS_IDLE: if (start) begin
                    st_q <= WS_PULSE;
                    pcnt <= '0;
                end
                WS_PULSE: if (pcnt == PW'(SYNC_CYC - 1)) begin
                    st_q <= WS_WAIT;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
                WS_WAIT: if (bclk_act) st_q <= WS_IDLE;
                default: st_q <= WS_IDLE;
            endcase
        end
    end

    // Output decode.
    assign sync_out = (st_q == WS_PULSE);
    assign busy     = (st_q != WS_IDLE);
endmodule

// File: rtl/lrs_ctrl_reg.sv
// Module: lrs_ctrl_reg
// Holds the cold-release bit and qualifies warm-reset requests.
// Assumes a single write port; the warm bit itself lives in the FSM.
module lrs_ctrl_reg
    import lrs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             bclk_act,
    input  logic             busy,
    output logic             cold_n,
    output logic             warm_start,
    output logic             warm_abort
);
    // Cold-release bit, zero out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     cold_n <= 1'b0;
        else if (wr_en) cold_n <= wr_data[COLD_BIT];
    end

    // Warm requests only count with cold released, bit clock idle, no warm active.
    assign warm_start = wr_en && wr_data[WARM_BIT] && cold_n && !bclk_act && !busy;
    // Entering cold reset cancels any warm reset at once.
    assign warm_abort = !cold_n || (wr_en && !wr_data[COLD_BIT]);
endmodule

// File: rtl/link_rst_seq.sv
// Module: link_rst_seq (top)
// Cold and warm reset sequencer for a serial audio codec link.
// Assumes bclk_in comes from the codec and is asynchronous to clk.
module link_rst_seq
    import lrs_pkg::*;
#(
    parameter int WIN_CYC  = 16,
    parameter int SYNC_CYC = 8,
    parameter int STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    output logic [1:0] rd_data,
    input  logic       bclk_in,
    output logic       codec_rst_n,
    output logic       sync_out
);
    logic bclk_act;
    logic busy;
    logic cold_n;
    logic warm_start;
    logic warm_abort;

    lrs_bclk_mon #(.WIN_CYC(WIN_CYC), .STAGES(STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .bclk_act(bclk_act)
    );

    lrs_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .bclk_act(bclk_act), .busy(busy), .cold_n(cold_n),
        .warm_start(warm_start), .warm_abort(warm_abort)
    );

    lrs_warm_fsm #(.SYNC_CYC(SYNC_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(warm_start), .abort(warm_abort),
        .bclk_act(bclk_act), .sync_out(sync_out), .busy(busy)
    );

    // Read-back and pin mapping.
    assign codec_rst_n        = cold_n;
    assign rd_data[COLD_BIT]  = cold_n;
    assign rd_data[WARM_BIT]  = busy;
endmodule

// File: rtl/link_rst_seq_chk.sv
// Module: link_rst_seq_chk
// Property checker bound to link_rst_seq.
module link_rst_seq_chk #(
    parameter int SYNC_CYC = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_data,
    input logic [1:0] rd_data,
    input logic       codec_rst_n,
    input logic       sync_out,
    input logic       bclk_act
);
    int unsigned hi_cnt;

    // Count consecutive cycles of sync high.
    always_ff @(posedge clk) begin
        if (!rst_n)        hi_cnt <= 0;
        else if (sync_out) hi_cnt <= hi_cnt + 1;
        else               hi_cnt <= 0;
    end

    // R2
    cold_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (codec_rst_n == $past(wr_data[0])));

    // R3
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt <= SYNC_CYC);

    // R4
    pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_out) |-> rd_data[1]);

    // R4
    warm_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_data[1]) && codec_rst_n) |-> $past(bclk_act));

    // R5
    no_warm_on_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_out) |-> !$past(bclk_act));

    // R9
    sync_cold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> codec_rst_n);
endmodule

bind link_rst_seq link_rst_seq_chk #(.SYNC_CYC(SYNC_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .codec_rst_n(codec_rst_n), .sync_out(sync_out),
    .bclk_act(bclk_act)
);

// File: tb/sim_link_rst_seq.sv
module sim_link_rst_seq;
    localparam int WIN  = 16;
    localparam int SYNC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_data = 2'b00;
    logic [1:0] rd_data;
    logic       bclk_in = 1'b0;
    logic       codec_rst_n;
    logic       sync_out;
    logic       bclk_on = 1'b0;
    int         n_chk = 0;
    int         n_bad = 0;

    link_rst_seq #(.WIN_CYC(WIN), .SYNC_CYC(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .bclk_in(bclk_in), .codec_rst_n(codec_rst_n),
        .sync_out(sync_out)
    );

    always #4 clk = ~clk;

    always begin
        if (bclk_on) #24 bclk_in = ~bclk_in;
        else         #8;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 2'b00;
    endtask

    task automatic clk_stop();
        bclk_on = 1'b0;
        cyc(WIN + 10);
    endtask

    task automatic clk_run();
        bclk_on = 1'b1;
        cyc(30);
    endtask

    task automatic t_reset();
        check("R1 codec_rst_n", codec_rst_n, 0);
        check("R1 sync_out", sync_out, 0);
        check("R1 rd_data", rd_data, 0);
    endtask

    task automatic t_cold();
        wr(2'b01);
        check("R2 release pin", codec_rst_n, 1);
        check("R2 release read", rd_data[0], 1);
        wr(2'b00);
        check("R2 hold pin", codec_rst_n, 0);
        wr(2'b01);
    endtask

    task automatic t_ignore_en();
        @(negedge clk);
        wr_data = 2'b10;
        cyc(3);
        wr_data = 2'b00;
        check("R10 pin", codec_rst_n, 1);
        check("R10 sync", sync_out, 0);
        check("R10 warm", rd_data[1], 0);
    endtask

    task automatic t_warm();
        int hi;
        clk_stop();
        @(negedge clk);
        wr_en = 1'b1; wr_data = 2'b11;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 2'b00;
        hi = 0;
        while (sync_out && hi < 100) begin
            hi++;
            @(negedge clk);
        end
        check("R3 pulse width", hi, SYNC);
        check("R4 bit after pulse", rd_data[1], 1);
        wr(2'b01);
        check("R8 write zero keeps warm", rd_data[1], 1);
        cyc(20);
        check("R4 bit while clock stopped", rd_data[1], 1);
        clk_run();
        check("R4 bit cleared", rd_data[1], 0);
        check("R4 sync low", sync_out, 0);
    endtask

    task automatic t_clk_running();
        int seen = 0;
        wr(2'b11);
        for (int i = 0; i < 20; i++) begin
            if (sync_out) seen = 1;
            @(negedge clk);
        end
        check("R5 no sync", seen, 0);
        check("R5 bit stays 0", rd_data[1], 0);
    endtask

    task automatic t_restop_abort();
        clk_stop();
        wr(2'b11);
        check("R7 warm accepted after window", sync_out, 1);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 2'b00;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 abort sync", sync_out, 0);
        check("R8 abort bit", rd_data[1], 0);
        check("R8 abort pin", codec_rst_n, 0);
    endtask

    task automatic t_cold_held();
        int seen = 0;
        wr(2'b10);
        check("R6 warm while held bit", rd_data[1], 0);
        check("R6 warm while held sync", sync_out, 0);
        wr(2'b11);
        for (int i = 0; i < 12; i++) begin
            if (sync_out || rd_data[1]) seen = 1;
            @(negedge clk);
        end
        check("R6 combined write pin", codec_rst_n, 1);
        check("R6 combined write no warm", seen, 0);
    endtask

    initial begin : wd
        cyc(20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_cold();
        t_ignore_en();
        t_warm();
        t_clk_running();
        t_restop_abort();
        t_cold_held();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule